// File: doc/BRIEF.md
# Dual-Rail Handshake Register Stage

This block is one storage stage of a clockless, delay-insensitive pipeline whose words use dual-rail encoding. Each logical bit travels on a pair of wires, a "one" rail and a "zero" rail. The all-zero vector is the spacer, a word that carries no data. A data word has exactly one rail high in every bit. The stage alternates between holding a data word and holding the spacer. A request/acknowledge handshake controls it.

The stage's request is the inverse of the acknowledge returned by the next stage. Each rail of each bit is a state-holding cell that acts as a two-input C-element. Its inputs are the incoming rail and the request. The cell sets when both are high, clears when both are low, and holds in every other case. A completion detector watches the stored word and drives the acknowledge back to the previous stage. It raises the acknowledge once every stored bit carries a value, and drops it once every stored rail is low.

The state-holding gates are emulated by flops that update on every edge of a fast simulation clock, so the design has no combinational loops. An input bit with both rails high is illegal. The stage flags it on a combinational error output and does not store it.

The completion detector is a two-state machine:
- `CD_SPACER`: acknowledge low. Transition `T_FILL` goes to `CD_DATA` when the stored word is a complete data word.
- `CD_DATA`: acknowledge high. Transition `T_DRAIN` goes back to `CD_SPACER` when the stored word is all zero.

In any other stored pattern, each state stays where it is.

Top module: `ncl_reg_stage`

## Requirements
- R1: While `rst_n` is low and after its release, the stage holds the spacer: all stored rails are 0 and `prv_ack` is 0.
- R2: With `nxt_ack` low (request high), an input rail that is high is stored one clock later. Value 1 is encoded as one-rail=1, zero-rail=0, and value 0 as one-rail=0, zero-rail=1.
- R3: A stored rail that is high stays high while its input rail or the request is high. It clears one clock after both are low.
- R4: With `nxt_ack` high (request low), a stored rail that is low stays low, whatever the input.
- R5: `prv_ack` rises one clock after the stored word becomes a complete data word (every bit with one rail high). It stays low while any bit is still empty.
- R6: `prv_ack` falls one clock after the stored word becomes all zero. While the stored word is partly filled, `prv_ack` keeps its value.
- R7: `illegal` is high in the same cycle that any input bit has both rails high. While it is high, the stored word does not change.
- R8: A stored bit never has both rails high. A rail does not set while its partner rail is stored high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Emulation clock that samples all state-holding cells |
| rst_n | input | 1 | Active-low reset to the spacer state |
| in_rail1 | input | WIDTH | Incoming one-rails |
| in_rail0 | input | WIDTH | Incoming zero-rails |
| nxt_ack | input | 1 | Acknowledge from the next stage; the request is its inverse |
| out_rail1 | output | WIDTH | Stored one-rails |
| out_rail0 | output | WIDTH | Stored zero-rails |
| prv_ack | output | 1 | Completion acknowledge sent to the previous stage |
| illegal | output | 1 | High when any input bit has both rails high |

## Verification
A cell stuck in the wrong state appears on `out_rail1`/`out_rail0` one clock after the stimulus that should have moved it. Examples are a rail that ignores the request, fails to hold, or clears too early. A wrong completion-detector state appears on `prv_ack` one clock later. The acknowledge then rises on a partly filled word, stays high on the spacer, or never rises. The sweep drives every data value of a small configuration through a full fill, hold and drain cycle, so each rail and each detector transition is exercised.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

    typedef enum logic [0:0] {
        CD_SPACER = 1'b0,
        CD_DATA   = 1'b1
    } cd_state_e;

endpackage

// File: rtl/ncl_rail_cell.sv
module ncl_rail_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic req_i,
    input  logic in1_i,
    input  logic in0_i,
    output logic q1_o,
    output logic q0_o
);

    logic set1, set0, clr1, clr0;

    always_comb begin
        set1 = in1_i & req_i & ~q0_o;
        set0 = in0_i & req_i & ~q1_o;
        clr1 = ~in1_i & ~req_i;
        clr0 = ~in0_i & ~req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q1_o <= 1'b0;
            q0_o <= 1'b0;
        end else if (en_i) begin
            if (set1)      q1_o <= 1'b1;
            else if (clr1) q1_o <= 1'b0;
            if (set0)      q0_o <= 1'b1;
            else if (clr0) q0_o <= 1'b0;
        end
    end

    p_hold_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q1_o && (in1_i || req_i)) |=> q1_o);
    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q0_o && (in0_i || req_i)) |=> q0_o);
    p_no_set_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !q1_o) |=> !q1_o);
    p_no_set_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !q0_o) |=> !q0_o);
    p_never_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(q1_o && q0_o));

endmodule

// File: rtl/ncl_completion.sv
module ncl_completion
    import ncl_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail1_i,
    input  logic [WIDTH-1:0] rail0_i,
    output logic             ack_o
);

    cd_state_e  state_q, state_d;
    logic [WIDTH-1:0] bit_valid;
    logic word_full, word_empty;

    always_comb begin
        bit_valid  = rail1_i | rail0_i;
        word_full  = &bit_valid;
        word_empty = ~|bit_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CD_SPACER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CD_SPACER: if (word_full)  state_d = CD_DATA;
            CD_DATA:   if (word_empty) state_d = CD_SPACER;
            default:   state_d = CD_SPACER;
        endcase
    end

    always_comb begin
        ack_o = (state_q == CD_DATA);
    end

    p_ack_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_full && !ack_o) |=> ack_o);
    p_ack_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_empty && ack_o) |=> !ack_o);
    p_ack_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_full && !word_empty) |=> $stable(ack_o));

endmodule

// File: rtl/ncl_reg_stage.sv
module ncl_reg_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_rail1,
    input  logic [WIDTH-1:0] in_rail0,
    input  logic             nxt_ack,
    output logic [WIDTH-1:0] out_rail1,
    output logic [WIDTH-1:0] out_rail0,
    output logic             prv_ack,
    output logic             illegal
);

    logic req;
    logic store_en;

    always_comb begin
        req      = ~nxt_ack;
        illegal  = |(in_rail1 & in_rail0);
        store_en = ~illegal;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        ncl_rail_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (store_en),
            .req_i (req),
            .in1_i (in_rail1[b]),
            .in0_i (in_rail0[b]),
            .q1_o  (out_rail1[b]),
            .q0_o  (out_rail0[b])
        );
    end

    ncl_completion #(.WIDTH(WIDTH)) u_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail1_i (out_rail1),
        .rail0_i (out_rail0),
        .ack_o   (prv_ack)
    );

    p_illegal_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> ($stable(out_rail1) && $stable(out_rail0)));
    p_set_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_ack && out_rail1 == '0) |=> (out_rail1 == '0));

endmodule

// File: tb/ncl_reg_stage_bench.sv
module ncl_reg_stage_bench;

    localparam int W = 3;
    localparam logic [W-1:0] MASK = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] in_rail1 = '0;
    logic [W-1:0] in_rail0 = '0;
    logic nxt_ack = 1'b0;
    logic [W-1:0] out_rail1, out_rail0;
    logic prv_ack, illegal;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    ncl_reg_stage #(.WIDTH(W)) u_ncl_reg_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_rail1  (in_rail1),
        .in_rail0  (in_rail0),
        .nxt_ack   (nxt_ack),
        .out_rail1 (out_rail1),
        .out_rail0 (out_rail0),
        .prv_ack   (prv_ack),
        .illegal   (illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_rail1 = '0; in_rail0 = '0; nxt_ack = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: held in reset
        step();
        chk("R1 rails in reset", {out_rail1, out_rail0}, '0);
        chk("R1 ack in reset", prv_ack, 0);
        rst_n = 1'b1;
        step();
        chk("R1 rails after release", {out_rail1, out_rail0}, '0);
        chk("R1 ack after release", prv_ack, 0);

        // Full sweep of every data value through fill, hold and drain
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] e1, e0;
            e1 = v[W-1:0];
            e0 = ~e1 & MASK;
            nxt_ack = 1'b0; in_rail1 = e1; in_rail0 = e0;
            step();
            chk("R2 one-rails stored", out_rail1, e1);
            chk("R2 zero-rails stored", out_rail0, e0);
            chk("R5 ack not yet", prv_ack, 0);
            step();
            chk("R5 ack raised", prv_ack, 1);
            in_rail1 = '0; in_rail0 = '0;
            step();
            chk("R3 hold with request high", {out_rail1, out_rail0}, {e1, e0});
            nxt_ack = 1'b1;
            step();
            chk("R3 cleared", {out_rail1, out_rail0}, '0);
            chk("R6 ack still high", prv_ack, 1);
            step();
            chk("R6 ack dropped", prv_ack, 0);
            nxt_ack = 1'b0;
            step();
        end

        // R4: request low blocks storage
        do_reset();
        nxt_ack = 1'b1; in_rail1 = 3'b101; in_rail0 = 3'b010;
        step(); step();
        chk("R4 no store without request", {out_rail1, out_rail0}, '0);
        chk("R4 ack low", prv_ack, 0);

        // R5/R6: partial word
        do_reset();
        in_rail1 = 3'b001; in_rail0 = 3'b000;
        step(); step();
        chk("R5 partial word stored", out_rail1, 3'b001);
        chk("R5 partial word no ack", prv_ack, 0);
        in_rail1 = 3'b011; in_rail0 = 3'b100;
        step(); step();
        chk("R5 completed word ack", prv_ack, 1);
        nxt_ack = 1'b1; in_rail1 = 3'b011; in_rail0 = 3'b000;
        step(); step();
        chk("R6 partial drain keeps ack", prv_ack, 1);
        chk("R6 partial drain rails", {out_rail1, out_rail0}, {3'b011, 3'b000});

        // R7: illegal input flagged and not stored
        do_reset();
        in_rail1 = 3'b010; in_rail0 = 3'b010;
        #1;
        chk("R7 illegal flagged", illegal, 1);
        step();
        chk("R7 illegal not stored", {out_rail1, out_rail0}, '0);
        in_rail1 = 3'b110; in_rail0 = 3'b001;
        #1;
        chk("R7 legal not flagged", illegal, 0);
        step();
        chk("R7 legal stored", out_rail1, 3'b110);
        in_rail1 = 3'b000; in_rail0 = 3'b111;
        nxt_ack = 1'b1;
        in_rail1 = 3'b001; in_rail0 = 3'b001;
        step();
        chk("R7 freeze during illegal", {out_rail1, out_rail0}, {3'b110, 3'b001});

        // R8: switching to the complement without a spacer
        do_reset();
        in_rail1 = 3'b101; in_rail0 = 3'b010;
        step();
        in_rail1 = 3'b010; in_rail0 = 3'b101;
        step(); step();
        chk("R8 no partner set", {out_rail1, out_rail0}, {3'b101, 3'b010});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule